// File: doc/BRIEF.md
# Paged SRAM Checkerboard Tester

This block tests a pair of external asynchronous static RAMs that share one data bus and one address bus. Each address is made of a page number held in a register and an offset that counts directly. After a start request the block fills both chips with an alternating bit pattern, visiting each address once and writing chip 0 and then chip 1 before it advances. It then reads back every location of chip 0, and after that every location of chip 1, comparing each byte with the pattern it expects.

A mismatch raises an error flag that stays set until the next test begins, and the test always runs to the end. A one-cycle completion pulse marks the end of the test. The data bus is split into a drive value, a drive enable and a receive value, so that the pad ring can build the tri-state buffer.

Top module: `paged_sram_tester`

## Requirements
- R1: `busy` goes high in the cycle after `start` is sampled in idle. It stays high until `done` pulses for exactly one cycle, and `busy` is low in that cycle. With 2^(PAGE_W+OFF_W) = N addresses and a write pulse of W cycles, `busy` is high for N*2*(W+2) + 4*N + 2 cycles.
- R2: The byte written to offset o is 55h when o is even and AAh when o is odd. After the write pass, every location of both chips holds its pattern byte.
- R3: Each write-enable low pulse lasts WE_CYCLES clock cycles. Address and data are unchanged in the cycle before the pulse and in the cycle after it.
- R4: During the write pass, the k-th write pulse goes to chip k mod 2 at address k/2. There are 2*N writes in total.
- R5: The read pass reads every location of chip 0 before any location of chip 1. At most one chip has its chip enable, output enable or write enable low at any time.
- R6: The block never drives the data bus while any output enable is low. At least one cycle separates its last driven cycle from the first cycle with an output enable low.
- R7: A read byte that differs from the expected byte sets `error`, and the test still completes with the same duration.
- R8: `error` stays set after the test ends. It clears only in the cycle after a start is accepted.
- R9: `start` has no effect while `busy` is high. The run length, the write order and the result are unchanged.
- R10: The address is {page, offset}. The offset counts 0 to its maximum, and when it wraps the page steps by one before the next access. After the last page the page and the offset are both 0, so `ramAddr` reads 0 once the test ends.
- R11: Under reset and after it, `busy`, `done`, `error` and `ramDataOe` are low, and all chip-enable, output-enable and write-enable lines are high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a test when idle |
| busy | output | 1 | Test in progress |
| done | output | 1 | One-cycle end-of-test pulse |
| error | output | 1 | Sticky mismatch flag |
| ramCeN | output | 2 | Per-chip chip enable, active low |
| ramOeN | output | 2 | Per-chip output enable, active low |
| ramWeN | output | 2 | Per-chip write enable, active low |
| ramAddr | output | PAGE_W+OFF_W | Shared address {page, offset} |
| ramDataOut | output | DATA_W | Write data toward the bus |
| ramDataOe | output | 1 | Enable for the block's bus driver |
| ramDataIn | input | DATA_W | Data received from the bus |

## Verification
The assertions assume that the external RAM presents read data within the cycle after its output enable falls. They also assume that `ramDataIn` comes from whichever chip is enabled. The bench's memory model answers combinationally from its array, so read data is settled well before the comparing edge. The turnaround and single-driver properties rely on reset returning every control to its inactive level. The bench only asserts reset between runs or in a directed reset check, and it drives `start` for one cycle, including the deliberate pulse in the middle of a run.

// File: rtl/tester_pkg.sv
package tester_pkg;

  typedef enum logic [2:0] {
    S_IDLE, S_WSET, S_WPUL, S_WHLD, S_GAP, S_RACC, S_RCMP, S_DONE
  } stateT;

  // one-cycle commands to the datapath
  typedef struct packed {
    logic clear;
    logic advance;
    logic flipChip;
    logic compare;
  } cmdT;

  // registered bus phase flags
  typedef struct packed {
    logic access;
    logic readEn;
    logic wePulse;
    logic drive;
  } phaseT;

endpackage

// File: rtl/tester_ctrl.sv
module tester_ctrl
  import tester_pkg::*;
#(
  parameter int WE_CYCLES = 2
) (
  input  logic  clk,
  input  logic  rstN,
  input  logic  start,
  input  logic  lastAddr,
  input  logic  chipSel,
  output cmdT   cmd,
  output phaseT phase,
  output logic  busy,
  output logic  done
);

  localparam int CW = $clog2(WE_CYCLES + 1);
  localparam logic [CW-1:0] PULSE_LAST = CW'(WE_CYCLES - 1);

  stateT state, nxt;
  logic [CW-1:0] pulseCnt;

  function automatic phaseT phaseOf(stateT s);
    phaseT p;
    p = '0;
    case (s)
      S_WSET, S_WHLD: begin p.access = 1'b1; p.drive = 1'b1; end
      S_WPUL: begin p.access = 1'b1; p.drive = 1'b1; p.wePulse = 1'b1; end
      S_RACC, S_RCMP: begin p.access = 1'b1; p.readEn = 1'b1; end
      default: ;
    endcase
    return p;
  endfunction

  always_comb begin
    cmd = '0;
    nxt = state;
    case (state)
      S_IDLE: if (start) begin cmd.clear = 1'b1; nxt = S_WSET; end
      S_WSET: nxt = S_WPUL;
      S_WPUL: if (pulseCnt == PULSE_LAST) nxt = S_WHLD;
      S_WHLD: begin
        cmd.flipChip = 1'b1;
        nxt = S_WSET;
        if (chipSel) begin
          cmd.advance = 1'b1;
          if (lastAddr) nxt = S_GAP;
        end
      end
      S_GAP:  nxt = S_RACC;
      S_RACC: nxt = S_RCMP;
      S_RCMP: begin
        cmd.compare = 1'b1;
        cmd.advance = 1'b1;
        nxt = S_RACC;
        if (lastAddr) begin
          if (!chipSel) begin cmd.flipChip = 1'b1; nxt = S_GAP; end
          else nxt = S_DONE;
        end
      end
      S_DONE: nxt = S_IDLE;
      default: nxt = S_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state    <= S_IDLE;
      phase    <= '0;
      pulseCnt <= '0;
    end else begin
      state    <= nxt;
      phase    <= phaseOf(nxt);
      pulseCnt <= (state == S_WPUL) ? pulseCnt + 1'b1 : '0;
    end
  end

  assign busy = (state != S_IDLE) && (state != S_DONE);
  assign done = (state == S_DONE);

  p_done_single_r1: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);
  p_done_not_busy_r1: assert property (@(posedge clk) disable iff (!rstN)
    done |-> !busy);
  p_busy_from_start_r1: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |-> $past(start));

endmodule

// File: rtl/tester_dpath.sv
module tester_dpath
  import tester_pkg::*;
#(
  parameter int PAGE_W = 7,
  parameter int OFF_W  = 8,
  parameter int DATA_W = 8
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  cmdT                       cmd,
  input  phaseT                     phase,
  input  logic [DATA_W-1:0]         dataIn,
  output logic                      chipSel,
  output logic                      lastAddr,
  output logic [PAGE_W+OFF_W-1:0]   addr,
  output logic [DATA_W-1:0]         dataOut,
  output logic                      dataOe,
  output logic [1:0]                ceN,
  output logic [1:0]                oeN,
  output logic [1:0]                weN,
  output logic                      error
);

  localparam int CHIPS = 2;
  localparam logic [DATA_W-1:0] PAT_EVEN = {(DATA_W/2){2'b01}};
  localparam logic [DATA_W-1:0] PAT_ODD  = ~PAT_EVEN;

  logic [OFF_W-1:0]  offset;
  logic [PAGE_W-1:0] page;
  logic [DATA_W-1:0] expected;

  assign expected = offset[0] ? PAT_ODD : PAT_EVEN;
  assign lastAddr = (&offset) & (&page);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      offset  <= '0;
      page    <= '0;
      chipSel <= 1'b0;
      error   <= 1'b0;
    end else if (cmd.clear) begin
      offset  <= '0;
      page    <= '0;
      chipSel <= 1'b0;
      error   <= 1'b0;
    end else begin
      if (cmd.compare && (dataIn != expected)) error <= 1'b1;
      if (cmd.flipChip) chipSel <= ~chipSel;
      if (cmd.advance) begin
        offset <= offset + 1'b1;
        if (&offset) page <= page + 1'b1;
      end
    end
  end

  for (genvar c = 0; c < CHIPS; c++) begin : g_chip
    logic hit;
    assign hit    = (chipSel == 1'(c));
    assign ceN[c] = ~(phase.access  & hit);
    assign oeN[c] = ~(phase.readEn  & hit);
    assign weN[c] = ~(phase.wePulse & hit);
  end

  assign addr    = {page, offset};
  assign dataOut = expected;
  assign dataOe  = phase.drive;

  p_one_chip_r5: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(~ceN) && $onehot0(~oeN) && $onehot0(~weN));
  p_bus_free_r6: assert property (@(posedge clk) disable iff (!rstN)
    dataOe |-> &oeN);
  p_turnaround_r6: assert property (@(posedge clk) disable iff (!rstN)
    !(&oeN) |-> !$past(dataOe));
  p_setup_stable_r3: assert property (@(posedge clk) disable iff (!rstN)
    $fell(&weN) |-> $stable(addr) && $stable(dataOut));
  p_hold_stable_r3: assert property (@(posedge clk) disable iff (!rstN)
    $rose(&weN) |-> $stable(addr) && $stable(dataOut));
  p_err_after_read_r7: assert property (@(posedge clk) disable iff (!rstN)
    $rose(error) |-> $past(!(&oeN)));

endmodule

// File: rtl/paged_sram_tester.sv
module paged_sram_tester
  import tester_pkg::*;
#(
  parameter int PAGE_W    = 7,
  parameter int OFF_W     = 8,
  parameter int DATA_W    = 8,
  parameter int WE_CYCLES = 2
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    start,
  output logic                    busy,
  output logic                    done,
  output logic                    error,
  output logic [1:0]              ramCeN,
  output logic [1:0]              ramOeN,
  output logic [1:0]              ramWeN,
  output logic [PAGE_W+OFF_W-1:0] ramAddr,
  output logic [DATA_W-1:0]       ramDataOut,
  output logic                    ramDataOe,
  input  logic [DATA_W-1:0]       ramDataIn
);

  cmdT   cmd;
  phaseT phase;
  logic  lastAddr;
  logic  chipSel;

  tester_ctrl #(.WE_CYCLES(WE_CYCLES)) u_ctrl (
    .clk(clk), .rstN(rstN), .start(start), .lastAddr(lastAddr),
    .chipSel(chipSel), .cmd(cmd), .phase(phase), .busy(busy), .done(done)
  );

  tester_dpath #(.PAGE_W(PAGE_W), .OFF_W(OFF_W), .DATA_W(DATA_W)) u_dpath (
    .clk(clk), .rstN(rstN), .cmd(cmd), .phase(phase), .dataIn(ramDataIn),
    .chipSel(chipSel), .lastAddr(lastAddr), .addr(ramAddr),
    .dataOut(ramDataOut), .dataOe(ramDataOe), .ceN(ramCeN), .oeN(ramOeN),
    .weN(ramWeN), .error(error)
  );

  p_err_sticky_r8: assert property (@(posedge clk) disable iff (!rstN)
    $fell(error) |-> $past(start && !busy));

endmodule

// File: tb/tb_paged_sram_tester.sv
`timescale 1ns/100ps
module tb_paged_sram_tester;

  localparam int PW = 2;
  localparam int OW = 3;
  localparam int AW = PW + OW;
  localparam int N  = 1 << AW;
  localparam int WE = 2;
  localparam int RUN_CYCLES = N * 2 * (WE + 2) + 4 * N + 2;

  // {midStart, expErr, faultChip, faultAddr[7:0], faultMask[7:0]}
  localparam int NV = 5;
  localparam logic [18:0] VEC [NV] = '{
    {1'b0, 1'b0, 1'b0, 8'd0,  8'h00},
    {1'b0, 1'b1, 1'b0, 8'd0,  8'h01},
    {1'b1, 1'b1, 1'b1, 8'd31, 8'h80},
    {1'b0, 1'b1, 1'b1, 8'd8,  8'h10},
    {1'b1, 1'b0, 1'b0, 8'd0,  8'h00}
  };

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic start = 1'b0;
  logic busy, done, error, ramDataOe;
  logic [1:0] ramCeN, ramOeN, ramWeN;
  logic [AW-1:0] ramAddr;
  logic [7:0] ramDataOut, ramDataIn;

  always #2.5 clk = ~clk;

  paged_sram_tester #(.PAGE_W(PW), .OFF_W(OW), .DATA_W(8), .WE_CYCLES(WE)) dut (
    .clk(clk), .rstN(rstN), .start(start), .busy(busy), .done(done),
    .error(error), .ramCeN(ramCeN), .ramOeN(ramOeN), .ramWeN(ramWeN),
    .ramAddr(ramAddr), .ramDataOut(ramDataOut), .ramDataOe(ramDataOe),
    .ramDataIn(ramDataIn)
  );

  logic [7:0] mem0 [N];
  logic [7:0] mem1 [N];
  logic       fChip;
  logic [7:0] fAddr, fMask;

  assign ramDataIn = (!ramCeN[0] && !ramOeN[0]) ? mem0[ramAddr] :
                     (!ramCeN[1] && !ramOeN[1]) ? mem1[ramAddr] : 8'h00;

  int total = 0, bad = 0;
  int wIdx, orderBad, pulseBad, weRun, busBad, readBad, rd0, rd1;
  logic prevWeAll = 1'b1, saw1;

  function automatic logic [7:0] pat(int a);
    return a[0] ? 8'hAA : 8'h55;
  endfunction

  task automatic check(input logic ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // bus monitor and memory model
  always @(negedge clk) begin
    if (!(&ramWeN)) begin
      if (prevWeAll) begin
        if ((!ramWeN[1]) != wIdx[0] || int'(ramAddr) != wIdx / 2) orderBad++;
        wIdx++;
      end
      weRun++;
    end else if (!prevWeAll) begin
      if (weRun != WE) pulseBad++;
      weRun = 0;
    end
    prevWeAll = &ramWeN;
    if (!ramCeN[0] && !ramWeN[0])
      mem0[ramAddr] = ramDataOut ^ ((fChip == 1'b0 && 8'(ramAddr) == fAddr) ? fMask : 8'h00);
    if (!ramCeN[1] && !ramWeN[1])
      mem1[ramAddr] = ramDataOut ^ ((fChip == 1'b1 && 8'(ramAddr) == fAddr) ? fMask : 8'h00);
    if (ramDataOe && !(&ramOeN)) busBad++;
    if (!ramCeN[0] && !ramOeN[0]) begin if (saw1) readBad++; rd0++; end
    if (!ramCeN[1] && !ramOeN[1]) begin saw1 = 1'b1; rd1++; end
  end

  task automatic runVec(input logic [18:0] v);
    logic mid, expErr, prevErr, gotDone;
    int busyCnt, cyc, memBad;
    mid = v[18]; expErr = v[17];
    fChip = v[16]; fAddr = v[15:8]; fMask = v[7:0];
    for (int a = 0; a < N; a++) begin mem0[a] = 8'hC3; mem1[a] = 8'hC3; end
    wIdx = 0; orderBad = 0; pulseBad = 0; weRun = 0; busBad = 0;
    readBad = 0; rd0 = 0; rd1 = 0; saw1 = 1'b0;
    prevErr = error;
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
    if (prevErr) check(error == 1'b0, "R8 clear on start", int'(error), 0);
    busyCnt = 0; cyc = 0; gotDone = 1'b0;
    while (!gotDone && cyc < 5000) begin
      if (busy) busyCnt++;
      if (done) begin
        gotDone = 1'b1;
        check(!busy, "R1 busy low with done", int'(busy), 0);
      end
      start = mid && (busyCnt == 100);
      cyc++;
      if (!gotDone) @(negedge clk);
    end
    start = 1'b0;
    check(gotDone, "R1 done reached (watchdog)", int'(gotDone), 1);
    check(busyCnt == RUN_CYCLES, mid ? "R9 run length with stray start" : "R1 run length",
          busyCnt, RUN_CYCLES);
    @(negedge clk);
    check(!done, "R1 done one cycle", int'(done), 0);
    check(int'(ramAddr) == 0, "R10 address back to zero", int'(ramAddr), 0);
    check(error == expErr, "R7 error result", int'(error), int'(expErr));
    memBad = 0;
    for (int a = 0; a < N; a++) begin
      if (mem0[a] != (pat(a) ^ ((fChip == 1'b0 && fAddr == 8'(a)) ? fMask : 8'h00))) memBad++;
      if (mem1[a] != (pat(a) ^ ((fChip == 1'b1 && fAddr == 8'(a)) ? fMask : 8'h00))) memBad++;
    end
    check(memBad == 0, "R2 pattern in memory", memBad, 0);
    check(pulseBad == 0, "R3 write pulse width", pulseBad, 0);
    check(orderBad == 0, "R4 R10 write order and address", orderBad, 0);
    check(wIdx == 2 * N, "R4 write count", wIdx, 2 * N);
    check(readBad == 0, "R5 chip 0 read before chip 1", readBad, 0);
    check(rd0 == 2 * N && rd1 == 2 * N, "R5 read cycles per chip", rd0 + rd1, 4 * N);
    check(busBad == 0, "R6 no drive while output enabled", busBad, 0);
    repeat (3) @(negedge clk);
    check(error == expErr, "R8 error held after end", int'(error), int'(expErr));
  endtask

  initial begin
    #(200000 * 5);
    bad++; total++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check(!busy && !done && !error && !ramDataOe, "R11 reset outputs",
          {busy, done, error, ramDataOe}, 0);
    check(ramCeN == 2'b11 && ramOeN == 2'b11 && ramWeN == 2'b11, "R11 reset strobes",
          {ramCeN, ramOeN, ramWeN}, 6'h3F);
    rstN = 1'b1;
    @(negedge clk);
    check(!busy && ramCeN == 2'b11, "R11 idle after reset", {busy, ramCeN}, 3);

    for (int i = 0; i < NV; i++) runVec(VEC[i]);

    // directed: reset in the middle of a run
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
    repeat (20) @(negedge clk);
    check(busy, "R1 busy during run", int'(busy), 1);
    rstN = 1'b0;
    @(negedge clk);
    check(!busy && !error && !ramDataOe && ramWeN == 2'b11 && ramCeN == 2'b11,
          "R11 reset mid-run", {busy, error, ramDataOe, ramWeN, ramCeN}, 15);
    rstN = 1'b1;
    repeat (2) @(negedge clk);
    check(!busy && !done, "R11 stays idle", {busy, done}, 0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule